// File: doc/BRIEF.md
# Strobed Control Word Sequencer

This block pushes a fixed series of seven words into a remote control register that latches on a strobe. Each word goes out as three back-to-back register writes: the word with the strobe bit clear, the same word with the strobe bit set, and the word with the strobe bit clear again. The series first writes a base control word, then that word with two clear-request bits added, then the base word once more. After that come four data words fetched from memory, which load a four-word instruction register at the far end.

A host supplies the base control word and the address of a four-word block, then pulses `start`. The sequencer latches both values, fetches each data word through a memory read port with one cycle of latency, and drives the output write port. It flags completion with a single-cycle `done`. A word counter (step 0 to 6) selects which word is framed next. States: IDLE (waiting; `start` here is the transition to PREP), PREP (a control step chooses its word and moves to LO1; a data step issues a memory read and moves to WAIT), WAIT (captures the read data, then LO1), LO1 → HI → LO2 (the three framed writes), LO2 → PREP (step below 6, counter advances) or LO2 → FIN (step 6), FIN (done pulse) → IDLE.

Top module: `strobe_seq`

## Requirements
- R1: After reset, `busy`, `done`, `out_we` and `mem_req` are all low.
- R2: Every word is written in three consecutive cycles with `out_we` high. In the first and third of those cycles `out_data` is the word with bit 6 (0x0040, the strobe) clear. In the middle cycle it is the same word with bit 6 set.
- R3: The seven words, in order, are: C, C | 0x4400, C, D0, D1, D2, D3. Here C is the latched control word and Dn is the memory word at block address + n. This gives exactly 21 writes per run.
- R4: Bit 6 is forced clear in every framed word outside the strobe-high write, even when the supplied control word or a data word has it set.
- R5: Each data word is fetched by one single-cycle `mem_req` pulse. Data words are requested at block address + 0, +1, +2, +3 in that order, with the address wrapping modulo 2^AW. `mem_rdata` is taken in the cycle after the request.
- R6: `done` is high for exactly one cycle, the cycle right after the last strobe-low write. `busy` is low in that cycle.
- R7: `busy` is high from the cycle after an accepted `start` through the last write. A run takes 33 cycles from the start cycle to `done`: 4 per control word, 5 per data word, plus one. `out_we` is never high while `busy` is low.
- R8: `start` is accepted only in IDLE. A pulse while busy or in the `done` cycle starts no further writes.
- R9: The control word and block address are sampled when `start` is accepted. Later changes on those inputs have no effect on the running series.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a series (accepted in IDLE only) |
| ctl_word | input | W | Base control word |
| blk_addr | input | AW | Address of the first of four data words |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read address |
| mem_rdata | input | W | Read data, valid the cycle after `mem_req` |
| out_we | output | 1 | Write strobe to the remote register port |
| out_data | output | W | Value written to the remote register port |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A corrupted step counter shows up at the ports as a wrong word value, a missing or extra word, or a wrong fetch address. This is visible at the very next LO1 write, or at the next `mem_req`, within at most five cycles. A wrong state transition breaks the low-high-low framing, or shifts the `done` pulse away from cycle 33, or makes the run length differ from 21 writes. The bench sweeps several control words, including ones with the strobe bit set, across several base addresses, including one that wraps. It compares each of the 21 writes against a value computed from the requirements, and checks the run timing. Some runs disturb the inputs mid-series and fire `start` during the run and in the `done` cycle.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREP,
        S_WAIT,
        S_LO1,
        S_HI,
        S_LO2,
        S_FIN
    } seq_state_t;

endpackage

// File: rtl/strobe_seq_fsm.sv
module strobe_seq_fsm
    import strobe_seq_pkg::*;
#(
    parameter int NUM_CTL  = 3,
    parameter int NUM_DATA = 4,
    localparam int NSTEP   = NUM_CTL + NUM_DATA,
    localparam int STEP_W  = $clog2(NSTEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic [STEP_W-1:0] step,
    output logic              is_data,
    output logic              accept,
    output logic              load_word,
    output logic              mem_req,
    output logic              frame_we,
    output logic              frame_hi,
    output logic              busy,
    output logic              done
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);
    localparam logic [STEP_W-1:0] FIRST_DATA = STEP_W'(NUM_CTL);

    seq_state_t state, nxt;

    assign is_data = (step >= FIRST_DATA);
    assign accept  = (state == S_IDLE) && start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            step  <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                step <= '0;
            end else if (state == S_LO2 && step != LAST_STEP) begin
                step <= step + 1'b1;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  nxt = start ? S_PREP : S_IDLE;
            S_PREP:  nxt = is_data ? S_WAIT : S_LO1;
            S_WAIT:  nxt = S_LO1;
            S_LO1:   nxt = S_HI;
            S_HI:    nxt = S_LO2;
            S_LO2:   nxt = (step == LAST_STEP) ? S_FIN : S_PREP;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        load_word = 1'b0;
        mem_req   = 1'b0;
        frame_we  = 1'b0;
        frame_hi  = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state)
            S_IDLE: busy = 1'b0;
            S_PREP: begin
                load_word = !is_data;
                mem_req   = is_data;
            end
            S_WAIT: load_word = 1'b1;
            S_LO1:  frame_we = 1'b1;
            S_HI: begin
                frame_we = 1'b1;
                frame_hi = 1'b1;
            end
            S_LO2:  frame_we = 1'b1;
            S_FIN: begin
                busy = 1'b0;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/strobe_seq_wordsel.sv
module strobe_seq_wordsel #(
    parameter int          W        = 16,
    parameter int          AW       = 8,
    parameter int          STB_BIT  = 6,
    parameter logic [W-1:0] CLR_MASK = 16'h4400,
    parameter int          CLR_STEP = 1,
    parameter int          NUM_CTL  = 3,
    parameter int          STEP_W   = 3
) (
    input  logic [STEP_W-1:0] step,
    input  logic              is_data,
    input  logic [W-1:0]      ctl_q,
    input  logic [AW-1:0]     base_q,
    input  logic [W-1:0]      mem_rdata,
    output logic [W-1:0]      word,
    output logic [AW-1:0]     mem_addr
);

    localparam logic [W-1:0] STB_MASK = W'(1) << STB_BIT;

    logic [W-1:0] raw;

    always_comb begin
        if (is_data) begin
            raw = mem_rdata;
        end else if (step == STEP_W'(CLR_STEP)) begin
            raw = ctl_q | CLR_MASK;
        end else begin
            raw = ctl_q;
        end
        word = raw & ~STB_MASK;
    end

    assign mem_addr = base_q + AW'(step) - AW'(NUM_CTL);

endmodule

// File: rtl/strobe_seq_framer.sv
module strobe_seq_framer #(
    parameter int W       = 16,
    parameter int STB_BIT = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_word,
    input  logic [W-1:0] word_in,
    input  logic         frame_we,
    input  logic         frame_hi,
    output logic         out_we,
    output logic [W-1:0] out_data
);

    localparam logic [W-1:0] STB_MASK = W'(1) << STB_BIT;

    logic [W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_word) begin
            word_q <= word_in;
        end
    end

    assign out_we   = frame_we;
    assign out_data = frame_hi ? (word_q | STB_MASK) : word_q;

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq #(
    parameter int           W        = 16,
    parameter int           AW       = 8,
    parameter int           STB_BIT  = 6,
    parameter logic [W-1:0] CLR_MASK = 16'h4400,
    parameter int           NUM_CTL  = 3,
    parameter int           NUM_DATA = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  ctl_word,
    input  logic [AW-1:0] blk_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic [W-1:0]  mem_rdata,
    output logic          out_we,
    output logic [W-1:0]  out_data,
    output logic          busy,
    output logic          done
);

    localparam int STEP_W = $clog2(NUM_CTL + NUM_DATA);

    logic [STEP_W-1:0] step;
    logic              is_data;
    logic              accept;
    logic              load_word;
    logic              frame_we;
    logic              frame_hi;
    logic [W-1:0]      ctl_q;
    logic [AW-1:0]     base_q;
    logic [W-1:0]      word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else if (accept) begin
            ctl_q  <= ctl_word;
            base_q <= blk_addr;
        end
    end

    strobe_seq_fsm #(
        .NUM_CTL  (NUM_CTL),
        .NUM_DATA (NUM_DATA)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .step      (step),
        .is_data   (is_data),
        .accept    (accept),
        .load_word (load_word),
        .mem_req   (mem_req),
        .frame_we  (frame_we),
        .frame_hi  (frame_hi),
        .busy      (busy),
        .done      (done)
    );

    strobe_seq_wordsel #(
        .W        (W),
        .AW       (AW),
        .STB_BIT  (STB_BIT),
        .CLR_MASK (CLR_MASK),
        .CLR_STEP (1),
        .NUM_CTL  (NUM_CTL),
        .STEP_W   (STEP_W)
    ) u_sel (
        .step      (step),
        .is_data   (is_data),
        .ctl_q     (ctl_q),
        .base_q    (base_q),
        .mem_rdata (mem_rdata),
        .word      (word),
        .mem_addr  (mem_addr)
    );

    strobe_seq_framer #(
        .W       (W),
        .STB_BIT (STB_BIT)
    ) u_frm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_word (load_word),
        .word_in   (word),
        .frame_we  (frame_we),
        .frame_hi  (frame_hi),
        .out_we    (out_we),
        .out_data  (out_data)
    );

endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
    parameter int W       = 16,
    parameter int STB_BIT = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mem_req,
    input logic         out_we,
    input logic [W-1:0] out_data,
    input logic         busy,
    input logic         done
);

    localparam logic [W-1:0] STB_MASK = W'(1) << STB_BIT;

    // R2: a strobe-high write is preceded by a strobe-low write
    a_r2_hi_after_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_data[STB_BIT]) |-> ($past(out_we) && !$past(out_data[STB_BIT])));

    // R2, R4: a strobe-high write is followed by the same word with strobe clear
    a_r2_lo_after_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_data[STB_BIT]) |=>
            (out_we && !out_data[STB_BIT] && out_data == ($past(out_data) & ~STB_MASK)));

    // R7: writes only happen while busy
    a_r7_we_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> busy);

    // R1, R7: idle means no writes and no fetches
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_we && !mem_req));

    // R6: done lasts one cycle and follows the final write
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(out_we) && $past(busy)));

    // R5: a fetch is a single-cycle pulse followed by a data capture cycle
    a_r5_req_gap: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> (!mem_req && !out_we));

endmodule

bind strobe_seq strobe_seq_chk #(
    .W       (W),
    .STB_BIT (STB_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .out_we   (out_we),
    .out_data (out_data),
    .busy     (busy),
    .done     (done)
);

// File: tb/strobe_seq_bench.sv
`timescale 1ns/1ps
module strobe_seq_bench;

    localparam int W  = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  ctl_word = '0;
    logic [AW-1:0] blk_addr = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [W-1:0]  mem_rdata = '0;
    logic          out_we;
    logic [W-1:0]  out_data;
    logic          busy;
    logic          done;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    strobe_seq u_strobe_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .ctl_word  (ctl_word),
        .blk_addr  (blk_addr),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .out_we    (out_we),
        .out_data  (out_data),
        .busy      (busy),
        .done      (done)
    );

    function automatic logic [W-1:0] mem_val(input logic [AW-1:0] a);
        return W'((32'(a) * 32'h1357) ^ 32'hA5E5);
    endfunction

    // Memory model: one cycle of read latency
    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_val(mem_addr);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_write(input int k, input logic [W-1:0] c,
                                               input logic [AW-1:0] b);
        int j = k / 3;
        int p = k % 3;
        logic [W-1:0] w;
        if (j == 1)      w = c | 16'h4400;
        else if (j < 3)  w = c;
        else             w = mem_val(b + AW'(j - 3));
        w = w & ~16'h0040;
        if (p == 1) w = w | 16'h0040;
        return w;
    endfunction

    task automatic run_seq(input logic [W-1:0] c, input logic [AW-1:0] b, input bit disturb);
        logic [W-1:0]  got [0:31];
        logic [AW-1:0] req_a [0:7];
        int nw = 0;
        int nreq = 0;
        int ndone = 0;
        int done_cyc = -1;
        int busy_bad = 0;
        int late_we = 0;
        @(negedge clk);
        start    = 1'b1;
        ctl_word = c;
        blk_addr = b;
        for (int cyc = 1; cyc <= 45; cyc++) begin
            @(negedge clk);
            if (out_we) begin
                if (nw < 32) got[nw] = out_data;
                nw++;
                if (cyc > 32) late_we++;
            end
            if (mem_req) begin
                if (nreq < 8) req_a[nreq] = mem_addr;
                nreq++;
            end
            if (done) begin
                ndone++;
                done_cyc = cyc;
                chk(!busy, "R6", "busy during done", 32'(busy), 0);
            end
            if (busy != (cyc <= 32)) busy_bad++;
            if (cyc == 1) start = 1'b0;
            if (disturb) begin
                if (cyc == 9) begin
                    start    = 1'b1;
                    ctl_word = ~c;
                    blk_addr = b + 8'd8;
                end
                if (cyc == 10) start = 1'b0;
                if (cyc == 33) start = 1'b1;
                if (cyc == 34) start = 1'b0;
            end
        end
        chk(nw == 21, "R3", "write count", 32'(nw), 21);
        for (int k = 0; k < 21 && k < nw; k++) begin
            logic [W-1:0] e = exp_write(k, c, b);
            chk(got[k] === e, (k % 3 == 1) ? "R2" : ((k / 3 < 3 && c[6]) ? "R4" : "R3"),
                $sformatf("write %0d", k), 32'(got[k]), 32'(e));
        end
        chk(nreq == 4, "R5", "fetch count", 32'(nreq), 4);
        for (int n = 0; n < 4 && n < nreq; n++) begin
            chk(req_a[n] === b + AW'(n), "R5", $sformatf("fetch addr %0d", n),
                32'(req_a[n]), 32'(b + AW'(n)));
        end
        chk(ndone == 1, "R6", "done pulse count", 32'(ndone), 1);
        chk(done_cyc == 33, "R7", "done cycle", 32'(done_cyc), 33);
        chk(busy_bad == 0, "R7", "busy window mismatches", 32'(busy_bad), 0);
        if (disturb) begin
            chk(late_we == 0, "R8", "writes after done", 32'(late_we), 0);
            chk(got[0] === exp_write(0, c, b), "R9", "first word kept", 32'(got[0]),
                32'(exp_write(0, c, b)));
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0]  ctls  [0:5];
        logic [AW-1:0] bases [0:3];
        ctls[0] = 16'h0000; ctls[1] = 16'hFFFF; ctls[2] = 16'h1234;
        ctls[3] = 16'h0040; ctls[4] = 16'hBBBF; ctls[5] = 16'h8001;
        bases[0] = 8'h00; bases[1] = 8'h05; bases[2] = 8'h7C; bases[3] = 8'hFE;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !out_we && !mem_req, "R1", "reset outputs",
            {28'd0, busy, done, out_we, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !out_we && !mem_req, "R1", "idle after reset",
            {28'd0, busy, done, out_we, mem_req}, 0);
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 4; j++) begin
                run_seq(ctls[i], bases[j], ((i + j) % 2) == 1);
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule